// File: doc/BRIEF.md
# Byte-Serial Left-Shift Writeback Unit

This unit finishes a left shift whose coarse, whole-byte part has already been done. The operand sits in the top bytes of a small byte-addressed scratch store: four bytes for a single-length operand and eight for a double-length one. The unit reads those bytes one per clock, starting at the least significant byte (the highest address). It shifts each byte left by a residual 0 to 3 bits and writes it into a byte lane of a 32-bit destination register. The bits that leave the top of a byte are staged in up to three carry flops and enter the bottom of the next, more significant byte. The first byte takes its incoming bits from carry values supplied with the start pulse.

For a double-length operand, the low word goes to the odd register of an even/odd pair and the high word then goes to the even register. The carries run straight across the boundary between the two registers. While the bytes are written, the unit keeps a running flag that is set if any written byte is nonzero. When the last byte is written it raises a one-cycle completion pulse and loads a sign-test mask that a following arithmetic step can use.

Top module: `lshift_wb`

## Requirements
- R1: After reset, `busy`, `done`, `wr_en` and `nonzero` are 0 and `sign_mask` is 0x00.
- R2: A `start` accepted at a clock edge makes the unit read one scratch byte per clock, starting in the next cycle. The reads run from address 0xFF downward: four bytes (0xFF..0xFC) when `dbl`=0, eight bytes (0xFF..0xF8) when `dbl`=1. `wr_en` is high in exactly those cycles.
- R3: Byte k of the sequence (k=0 first) goes to lane 3-(k mod 4), where lane 0 is the most significant byte of a register. With `dbl`=0, every byte goes to register `dest`. With `dbl`=1, bytes 0..3 go to `dest` with bit 0 forced to 1 and bytes 4..7 go to `dest` with bit 0 forced to 0.
- R4: With `shamt`=0, every written byte equals the scratch byte that was read, and `cin` has no effect.
- R5: With `shamt`=1, the written byte is the read byte shifted left one place. Its bit 0 is `cin[2]` for the first byte and bit 7 of the previous read byte for later bytes.
- R6: With `shamt`=2, the read byte is shifted left two places. For the first byte, bits [1:0] are {`cin[2]`, `cin[0]`}. For later bytes they are bits [7:6] of the previous read byte.
- R7: With `shamt`=3, the read byte is shifted left three places. For the first byte, bits [2:0] are {`cin[2]`, `cin[1]`, `cin[0]`}. For later bytes they are bits [7:5] of the previous read byte.
- R8: When `done` is high, `nonzero` is 1 exactly when at least one written byte of that operation was nonzero. The flag is cleared at the next accepted `start`.
- R9: `done` is high for exactly one cycle, in the cycle after the last write. `busy` is high from the cycle after acceptance through the last write cycle.
- R10: When `done` is high, `sign_mask` is 0x80 if `arith` was 1 at acceptance and 0x00 otherwise. It holds that value until the next accepted `start` clears it to 0x00.
- R11: A `start` pulse while `busy` is high is ignored. The running operation continues unchanged and ends at its original time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, accepted when not busy |
| shamt | input | 2 | Residual left-shift amount, 0..3 |
| arith | input | 1 | 1 = arithmetic shift, 0 = logical |
| dbl | input | 1 | 1 = double-length operand (register pair) |
| cin | input | 3 | Initial incoming bits: [2] first, [1] second (3-bit shift only), [0] last |
| dest | input | RIDX_W | Destination register index (even register of a pair) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_addr | output | ADDR_W | Scratch store read address |
| rd_data | input | 8 | Scratch store read data, same cycle |
| wr_en | output | 1 | Register byte write enable |
| wr_reg | output | RIDX_W | Register index being written |
| wr_lane | output | 2 | Byte lane within the register, 0 = most significant |
| wr_data | output | 8 | Shifted byte to write |
| nonzero | output | 1 | Some written byte was nonzero |
| sign_mask | output | 8 | Sign-test mask for a following arithmetic step |

## Verification
The hardest case to reach from the ports is a carry that crosses from the odd register into the even register of a double-length operand, with a shift of three. In that case all three staged bits come from byte 3 and must land in the low bits of byte 4. The stimulus places set top bits in scratch byte 0xFC, and it also places a single set bit in the most significant byte, which shifts out so that every written byte is zero. A 64-bit behavioural shift in the bench predicts every write. Ignored starts are pulsed partway through a double-length run with different parameters, and consecutive operations are started in the `done` cycle.

// File: rtl/lswb_pkg.sv
// Package: shared types for the byte-serial left-shift writeback unit.
// Assumes bytes of eight bits and at most three staged carry bits.
package lswb_pkg;
    // Staged carry bits: a enters first, b second (3-bit shift), c last.
    typedef struct packed {
        logic a;
        logic b;
        logic c;
    } carry_t;

    typedef logic [1:0] shamt_t;
endpackage

// File: rtl/lswb_seq.sv
// Sequencer: accepts a start, holds the operation settings and walks the
// byte steps from the least significant scratch byte upward. It derives the
// scratch address, the destination register and the byte lane of each step.
// Assumes the operand sits at the top of the scratch address space.
module lswb_seq
    import lswb_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int RIDX_W     = 4,
    parameter int WORD_BYTES = 4,
    localparam int LANE_W    = $clog2(WORD_BYTES),
    localparam int STEP_W    = $clog2(2 * WORD_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  shamt_t            shamt,
    input  logic              arith,
    input  logic              dbl,
    input  logic [RIDX_W-1:0] dest,
    output logic              accept,
    output logic              busy,
    output logic              last,
    output shamt_t            shamt_q,
    output logic              arith_q,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [RIDX_W-1:0] wr_reg,
    output logic [LANE_W-1:0] wr_lane
);
    localparam logic [STEP_W-1:0] LAST_SGL = STEP_W'(WORD_BYTES - 1);
    localparam logic [STEP_W-1:0] LAST_DBL = STEP_W'(2 * WORD_BYTES - 1);

    logic              busy_q;
    logic              dbl_q;
    logic [RIDX_W-1:0] dest_q;
    logic [STEP_W-1:0] step_q;

    assign accept = start && !busy_q;
    assign busy   = busy_q;
    assign last   = busy_q && (step_q == (dbl_q ? LAST_DBL : LAST_SGL));

    // Capture the settings on acceptance and advance one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            dbl_q   <= 1'b0;
            dest_q  <= '0;
            step_q  <= '0;
            shamt_q <= '0;
            arith_q <= 1'b0;
        end else if (accept) begin
            busy_q  <= 1'b1;
            dbl_q   <= dbl;
            dest_q  <= dest;
            step_q  <= '0;
            shamt_q <= shamt;
            arith_q <= arith;
        end else if (busy_q) begin
            if (last) begin
                busy_q <= 1'b0;
            end else begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    // Address, register and lane of the current step.
    always_comb begin
        rd_addr = {ADDR_W{1'b1}} - {{(ADDR_W - STEP_W){1'b0}}, step_q};
        wr_lane = LANE_W'(WORD_BYTES - 1) - step_q[LANE_W-1:0];
        if (step_q[LANE_W]) begin
            wr_reg = {dest_q[RIDX_W-1:1], 1'b0};
        end else if (dbl_q) begin
            wr_reg = {dest_q[RIDX_W-1:1], 1'b1};
        end else begin
            wr_reg = dest_q;
        end
    end
endmodule

// File: rtl/lswb_shift.sv
// Byte shifter: shifts one byte left by 0..3 places, filling the low end
// from the staged carries, and reports the bits that leave the top.
// Purely combinational; assumes BYTE_W of at least four.
module lswb_shift
    import lswb_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] byte_in,
    input  shamt_t            shamt,
    input  carry_t            cin,
    output logic [BYTE_W-1:0] byte_out,
    output carry_t            cout
);
    // Shift the byte and collect the outgoing bits for the next byte.
    always_comb begin
        unique case (shamt)
            2'd0:    byte_out = byte_in;
            2'd1:    byte_out = {byte_in[BYTE_W-2:0], cin.a};
            2'd2:    byte_out = {byte_in[BYTE_W-3:0], cin.a, cin.c};
            default: byte_out = {byte_in[BYTE_W-4:0], cin.a, cin.b, cin.c};
        endcase
        cout.a = byte_in[BYTE_W-1];
        cout.b = byte_in[BYTE_W-2];
        cout.c = (shamt == 2'd3) ? byte_in[BYTE_W-3] : byte_in[BYTE_W-2];
    end
endmodule

// File: rtl/lswb_status.sv
// Status: keeps the running nonzero flag over the written bytes, raises the
// one-cycle completion pulse and loads the sign-test mask at the end.
// Assumes accept and busy are never high together.
module lswb_status #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              busy,
    input  logic              last,
    input  logic              arith_q,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              done,
    output logic              nonzero,
    output logic [BYTE_W-1:0] sign_mask
);
    localparam logic [BYTE_W-1:0] SIGN_BIT = {1'b1, {(BYTE_W - 1){1'b0}}};

    // Track nonzero bytes, pulse completion and load the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            nonzero   <= 1'b0;
            sign_mask <= '0;
        end else begin
            done <= busy && last;
            if (accept) begin
                nonzero   <= 1'b0;
                sign_mask <= '0;
            end else if (busy) begin
                nonzero <= nonzero | (|wr_data);
                if (last) begin
                    sign_mask <= arith_q ? SIGN_BIT : '0;
                end
            end
        end
    end
endmodule

// File: rtl/lshift_wb.sv
// Top: byte-serial left-shift writeback. It reads the operand from the top
// of a scratch store (combinational read), shifts each byte by 0..3 places
// with staged carries between bytes, and writes it into register lanes.
// Assumes the scratch read data is valid in the same cycle as rd_addr.
module lshift_wb
    import lswb_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int RIDX_W     = 4,
    parameter int WORD_BYTES = 4,
    localparam int LANE_W    = $clog2(WORD_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        shamt,
    input  logic              arith,
    input  logic              dbl,
    input  logic [2:0]        cin,
    input  logic [RIDX_W-1:0] dest,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_en,
    output logic [RIDX_W-1:0] wr_reg,
    output logic [LANE_W-1:0] wr_lane,
    output logic [7:0]        wr_data,
    output logic              nonzero,
    output logic [7:0]        sign_mask
);
    logic   accept;
    logic   last;
    shamt_t shamt_q;
    logic   arith_q;
    carry_t carry_q;
    carry_t carry_nx;

    lswb_seq #(
        .ADDR_W    (ADDR_W),
        .RIDX_W    (RIDX_W),
        .WORD_BYTES(WORD_BYTES)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .shamt  (shamt),
        .arith  (arith),
        .dbl    (dbl),
        .dest   (dest),
        .accept (accept),
        .busy   (busy),
        .last   (last),
        .shamt_q(shamt_q),
        .arith_q(arith_q),
        .rd_addr(rd_addr),
        .wr_reg (wr_reg),
        .wr_lane(wr_lane)
    );

    lswb_shift #(
        .BYTE_W(8)
    ) u_shift (
        .byte_in (rd_data),
        .shamt   (shamt_q),
        .cin     (carry_q),
        .byte_out(wr_data),
        .cout    (carry_nx)
    );

    lswb_status #(
        .BYTE_W(8)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .busy     (busy),
        .last     (last),
        .arith_q  (arith_q),
        .wr_data  (wr_data),
        .done     (done),
        .nonzero  (nonzero),
        .sign_mask(sign_mask)
    );

    assign wr_en = busy;

    // Staged carries: load the start values, then the bits out of each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= '0;
        end else if (accept) begin
            carry_q <= '{a: cin[2], b: cin[1], c: cin[0]};
        end else if (busy) begin
            carry_q <= carry_nx;
        end
    end
endmodule

// File: rtl/lswb_chk.sv
// Checker: temporal properties of the writeback unit, bound to the top.
module lswb_chk #(
    parameter int ADDR_W = 8,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [BYTE_W-1:0] rd_data,
    input logic [BYTE_W-1:0] wr_data,
    input logic              nonzero,
    input logic [BYTE_W-1:0] sign_mask,
    input logic [1:0]        shamt_q
);
    localparam logic [BYTE_W-1:0] SIGN_BIT = {1'b1, {(BYTE_W - 1){1'b0}}};

    // R9: completion lasts a single cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: completion follows the end of the busy window
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R2: the first read is at the top address
    a_r2_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> rd_addr == {ADDR_W{1'b1}});

    // R2: later reads step down by one
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$rose(busy)) |-> rd_addr == $past(rd_addr) - 1'b1);

    // R4: zero shift copies the byte
    a_r4_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && shamt_q == 2'd0) |-> wr_data == rd_data);

    // R8: a nonzero written byte sets the flag
    a_r8_nonzero_set: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_data != '0) |=> nonzero);

    // R10: the mask at completion is either clear or the sign bit
    a_r10_mask_value: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sign_mask == SIGN_BIT || sign_mask == '0));

    // R11: a start while busy does not restart the walk
    a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> !(busy && rd_addr == {ADDR_W{1'b1}}));
endmodule

bind lshift_wb lswb_chk #(
    .ADDR_W(ADDR_W),
    .BYTE_W(8)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .wr_data  (wr_data),
    .nonzero  (nonzero),
    .sign_mask(sign_mask),
    .shamt_q  (shamt_q)
);

// File: tb/lshift_wb_bench.sv
`timescale 1ns/1ps
module lshift_wb_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] shamt = '0;
    logic       arith = 1'b0;
    logic       dbl = 1'b0;
    logic [2:0] cin = '0;
    logic [3:0] dest = '0;
    logic       busy, done, wr_en, nonzero;
    logic [7:0] rd_addr, rd_data, wr_data, sign_mask;
    logic [3:0] wr_reg;
    logic [1:0] wr_lane;

    logic [7:0] mem [0:255];
    assign rd_data = mem[rd_addr];

    always #4 clk = ~clk;

    lshift_wb u_lshift_wb (
        .clk(clk), .rst_n(rst_n), .start(start), .shamt(shamt), .arith(arith),
        .dbl(dbl), .cin(cin), .dest(dest), .busy(busy), .done(done),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_reg(wr_reg),
        .wr_lane(wr_lane), .wr_data(wr_data), .nonzero(nonzero),
        .sign_mask(sign_mask)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d",
                     tag, what, act, exp, cyc);
        end
    endtask

    // Behavioural reference model, updated on every clock edge.
    bit         m_busy = 0, m_done = 0, m_ign = 0, m_live = 0;
    int         m_k = 0, m_n = 0, m_sh = 0;
    logic [7:0] m_exp [8];
    logic [3:0] m_reg [8];
    logic [1:0] m_lane [8];
    logic       m_nz = 0;
    logic [7:0] m_mask = 0;
    string      sh_tag [4] = '{"R4", "R5", "R6", "R7"};

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_nz = 0; m_mask = 0; m_ign = 0;
        end else if (start && !m_busy) begin
            logic [63:0] v, fill, r;
            m_n = dbl ? 8 : 4;
            m_sh = shamt;
            v = 0;
            for (int i = 0; i < m_n; i++) v |= 64'(mem[8'(255 - i)]) << (8 * i);
            case (shamt)
                2'd1: fill = 64'(cin[2]);
                2'd2: fill = 64'({cin[2], cin[0]});
                2'd3: fill = 64'(cin);
                default: fill = 0;
            endcase
            r = (v << shamt) | fill;
            for (int i = 0; i < 8; i++) begin
                m_exp[i]  = r[8 * i +: 8];
                m_lane[i] = 2'(3 - (i % 4));
                m_reg[i]  = (i >= 4) ? {dest[3:1], 1'b0} :
                            (dbl ? {dest[3:1], 1'b1} : dest);
            end
            m_busy = 1; m_k = 0; m_nz = 0; m_mask = 0; m_done = 0;
            m_ign = 0; m_live = arith;
        end else if (m_busy) begin
            if (start) m_ign = 1;
            m_nz = m_nz | (m_exp[m_k] != 0);
            m_k++;
            m_done = 0;
            if (m_k == m_n) begin
                m_busy = 0;
                m_done = 1;
                m_mask = m_live ? 8'h80 : 8'h00;
            end
        end else begin
            m_done = 0;
        end
    end

    // Compare the design against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == m_busy, m_ign ? "R11" : "R9", "busy", 64'(busy), 64'(m_busy));
            chk(done == m_done, "R9", "done", 64'(done), 64'(m_done));
            chk(wr_en == m_busy, "R2", "wr_en", 64'(wr_en), 64'(m_busy));
            if (m_done) begin
                chk(nonzero == m_nz, "R8", "nonzero", 64'(nonzero), 64'(m_nz));
                chk(sign_mask == m_mask, "R10", "sign_mask", 64'(sign_mask), 64'(m_mask));
            end
            if (m_busy && wr_en) begin
                chk(rd_addr == 8'(255 - m_k), "R2", "rd_addr", 64'(rd_addr), 64'(255 - m_k));
                chk(wr_reg == m_reg[m_k], "R3", "wr_reg", 64'(wr_reg), 64'(m_reg[m_k]));
                chk(wr_lane == m_lane[m_k], "R3", "wr_lane", 64'(wr_lane), 64'(m_lane[m_k]));
                chk(wr_data == m_exp[m_k], sh_tag[m_sh], "wr_data", 64'(wr_data), 64'(m_exp[m_k]));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic load_op(input logic [63:0] val);
        for (int i = 0; i < 8; i++) mem[8'(255 - i)] = val[8 * i +: 8];
    endtask

    // Runs one operation; called at a negedge, returns at the done negedge.
    task automatic op(input logic [1:0] sh, input bit ar, input bit db,
                      input logic [2:0] ci, input logic [3:0] de, input bit poke);
        int guard;
        start = 1; shamt = sh; arith = ar; dbl = db; cin = ci; dest = de;
        @(negedge clk);
        start = 0;
        guard = 0;
        while (!done && guard < 40) begin
            if (poke && guard == 2) begin
                start = 1; shamt = ~sh; arith = ~ar; dbl = ~db; cin = ~ci; dest = ~de;
            end else begin
                start = 0;
            end
            @(negedge clk);
            guard++;
        end
        start = 0;
        chk(done == 1'b1, "R9", "done reached", 64'(done), 64'd1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7);
        repeat (3) @(negedge clk);
        // R1: reset state while held and just after release
        chk(busy == 0 && done == 0 && wr_en == 0, "R1", "ctrl in reset",
            64'({busy, done, wr_en}), 64'd0);
        rst_n = 1;
        @(negedge clk);
        chk(nonzero == 0, "R1", "nonzero after reset", 64'(nonzero), 64'd0);
        chk(sign_mask == 0, "R1", "mask after reset", 64'(sign_mask), 64'd0);
        chk(busy == 0, "R1", "busy after reset", 64'(busy), 64'd0);

        // R4: zero shift ignores the carries
        load_op(64'h0123_4567_89AB_CDEF);
        op(2'd0, 1'b0, 1'b0, 3'b111, 4'd5, 1'b0);
        // R5..R7 single length with distinct carry patterns
        op(2'd1, 1'b1, 1'b0, 3'b100, 4'd2, 1'b0);
        op(2'd2, 1'b0, 1'b0, 3'b101, 4'd3, 1'b0);
        op(2'd3, 1'b1, 1'b0, 3'b010, 4'd7, 1'b0);
        // Double length: carries cross from the odd into the even register
        load_op(64'h8000_0000_E000_00FF);
        op(2'd3, 1'b1, 1'b1, 3'b111, 4'd6, 1'b0);
        op(2'd2, 1'b0, 1'b1, 3'b001, 4'd9, 1'b0);
        op(2'd1, 1'b1, 1'b1, 3'b000, 4'd0, 1'b0);
        op(2'd0, 1'b0, 1'b1, 3'b110, 4'd4, 1'b0);
        // R8: all-zero operand, and a lone top bit that shifts out
        load_op(64'h0);
        op(2'd2, 1'b1, 1'b1, 3'b000, 4'd2, 1'b0);
        load_op(64'h0000_0000_8000_0000);
        op(2'd1, 1'b0, 1'b0, 3'b000, 4'd1, 1'b0);
        op(2'd1, 1'b0, 1'b0, 3'b100, 4'd1, 1'b0);
        // R11: starts during a run are ignored
        load_op(64'hDEAD_BEEF_0BAD_F00D);
        op(2'd3, 1'b1, 1'b1, 3'b101, 4'd8, 1'b1);
        op(2'd1, 1'b0, 1'b0, 3'b011, 4'd3, 1'b1);
        // Mixed stream, some back to back and some with idle gaps
        for (int t = 0; t < 80; t++) begin
            load_op({$urandom, $urandom});
            if (t % 5 == 0) load_op(64'h0);
            op(2'($urandom), 1'($urandom), 1'($urandom), 3'($urandom),
               4'($urandom), (t % 7) == 3);
            if (t % 3 == 0) repeat (2) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule